// File: doc/BRIEF.md
# Four-Window Host Slave with Streaming Data Channels

This block is the slave-side front end of a device that presents itself to a host as a memory with four banks. The two most significant bits of every host address select a window. Window 0 is a small register file for commands, status, a version word and a configuration stream. Windows 1 and 2 are data windows for the X and Y memory sides. Window 3 is a scratch RAM inside the block that the host reads and writes at any offset.

A transfer starts when the host writes a command word to the command register. The command names a side, one of two memories on that side, a starting address and a word count. These values arm the channel for that side. Each later host write to that side's data window goes out on a simple memory write port at the channel's current address. Each later read from that window returns the memory's word at the current address. In both cases the address then steps up by one and the remaining count drops by one. When the count reaches zero the channel goes idle. The bus timing layer and the memory controller are not part of this block. A combinational memory port stands in for them.

Top module: `bd_top`

## Requirements
- R1: After reset both channels are idle, all sticky bits are clear, the status word reads 0, and `hst_rvalid`, `mem_we`, `mem_re` and `cfg_valid` are low.
- R2: Address bits [9:8] select the window: 0 = register file, 1 = X data, 2 = Y data, 3 = scratch RAM. Bits [7:0] are the offset within the window.
- R3: A write to window 3 stores the data at offset bits [5:0]. A later read of the same offset returns the last value written there.
- R4: Writing offset 0 of window 0 issues a command. Bit 31 selects the side (0 = X, 1 = Y). Bit 30 selects the memory (0 = A, 1 = B). Bits [27:16] give the word count. Bits [11:0] give the base address. If that side's channel is idle and the count is non-zero, the channel becomes busy. A zero count leaves the channel idle.
- R5: While a side's channel is busy, each write to its data window drives `mem_we` in that cycle. `mem_side` shows the side, `mem_bsel` shows the commanded memory, and `mem_wdata` carries the host data. `mem_addr` is the base address for the first word, then base+1 and so on, wrapping modulo 4096.
- R6: Each data access decrements the remaining count. Offsets 4 (X) and 5 (Y) of window 0 read the remaining count. Status bit 0 (X) or bit 1 (Y) shows the channel busy, and the bit clears after the last counted word.
- R7: A data-window write or read to a side whose channel is idle produces no memory access and sets sticky status bit 2.
- R8: A read of a busy data window drives `mem_re` and returns `mem_rdata` sampled at the channel's current address. The address then advances as in R5.
- R9: A command for a side whose channel is busy is rejected and the channel's address, memory and count are unchanged. The rejection sets sticky status bit 3.
- R10: A write to offset 2 of window 0 pulses `cfg_valid` in the same cycle, with `cfg_data` equal to the written word, and sets sticky status bit 4.
- R11: Offset 3 of window 0 reads the fixed version value (default 32'h0001_0004).
- R12: Writing offset 1 of window 0 clears each of status bits 2, 3 and 4 whose position is 1 in the written data.
- R13: A read returns `hst_rvalid` high with `hst_rdata` exactly one cycle after `hst_rd`. When `hst_wr` and `hst_rd` are high in the same cycle, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 10 | Window (bits 9:8) and offset (bits 7:0) |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, registered |
| hst_rvalid | output | 1 | Read data valid |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_side | output | 1 | Memory side, 0 = X, 1 = Y |
| mem_bsel | output | 1 | Memory on that side, 0 = A, 1 = B |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, combinational |
| cfg_valid | output | 1 | Configuration word strobe |
| cfg_data | output | 32 | Configuration word |

## Verification
A channel whose address register is wrong shows a bad `mem_addr` on the very next data access. A channel whose count register is wrong shows up one read later at offset 4 or 5. A wrong busy flag appears in status bits 0 and 1. It also shows as a dropped or spurious `mem_we` on the next data write, together with the sticky error bit. The directed tests therefore read status and the remaining count right after each command and after each data word. They also log every memory write, so a slip in sequencing is reported within one transaction.

// File: rtl/bd_pkg.sv
package bd_pkg;
  typedef enum logic [1:0] {
    BK_CSR  = 2'd0,
    BK_XDAT = 2'd1,
    BK_YDAT = 2'd2,
    BK_SCR  = 2'd3
  } bank_e;

  localparam int OFS_CMD  = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_CFG  = 2;
  localparam int OFS_VER  = 3;
  localparam int OFS_XREM = 4;
  localparam int OFS_YREM = 5;

  localparam int CMD_SIDE    = 31;
  localparam int CMD_MSEL    = 30;
  localparam int CMD_CNT_LSB = 16;

  localparam int ST_BUSY0 = 0;
  localparam int ST_ERR   = 2;
  localparam int ST_OVR   = 3;
  localparam int ST_CFG   = 4;
endpackage

// File: rtl/bd_chan.sv
module bd_chan #(
  parameter int MEM_AW = 12,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              arm_msel,
  input  logic [MEM_AW-1:0] arm_base,
  input  logic [CNT_W-1:0]  arm_cnt,
  input  logic              step,
  output logic              busy,
  output logic              msel,
  output logic [MEM_AW-1:0] addr,
  output logic [CNT_W-1:0]  remain
);
  logic              busy_q, busy_d, msel_q, msel_d;
  logic [MEM_AW-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              en;

  assign en = arm | step;

  always_comb begin
    busy_d = busy_q;
    msel_d = msel_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    if (arm && !busy_q) begin
      if (arm_cnt != '0) begin
        busy_d = 1'b1;
        msel_d = arm_msel;
        addr_d = arm_base;
        rem_d  = arm_cnt;
      end
    end else if (step && busy_q) begin
      addr_d = addr_q + 1'b1;
      rem_d  = rem_q - 1'b1;
      if (rem_q == CNT_W'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      msel_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      msel_q <= msel_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign busy   = busy_q;
  assign msel   = msel_q;
  assign addr   = addr_q;
  assign remain = rem_q;
endmodule

// File: rtl/bd_scratch.sv
module bd_scratch #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];
endmodule

// File: rtl/bd_csr.sv
module bd_csr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] set,
  input  logic [2:0] clr,
  output logic [2:0] sticky
);
  logic [2:0] q, d;
  logic       en;

  assign en = (set != 3'b0) || (clr != 3'b0);

  always_comb d = (q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 3'b0;
    else if (en) q <= d;
  end

  assign sticky = q;
endmodule

// File: rtl/bd_top.sv
module bd_top
  import bd_pkg::*;
#(
  parameter int          DW      = 32,
  parameter int          OFF_W   = 8,
  parameter int          MEM_AW  = 12,
  parameter int          CNT_W   = 12,
  parameter int          SCR_AW  = 6,
  parameter logic [31:0] VERSION = 32'h0001_0004
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hst_wr,
  input  logic                  hst_rd,
  input  logic [OFF_W+1:0]      hst_addr,
  input  logic [DW-1:0]         hst_wdata,
  output logic [DW-1:0]         hst_rdata,
  output logic                  hst_rvalid,
  output logic                  mem_we,
  output logic                  mem_re,
  output logic                  mem_side,
  output logic                  mem_bsel,
  output logic [MEM_AW-1:0]     mem_addr,
  output logic [DW-1:0]         mem_wdata,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  cfg_valid,
  output logic [DW-1:0]         cfg_data
);
  localparam int HA_W   = OFF_W + 2;
  localparam int NCHAN  = 2;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  bank_e            bank;
  logic [OFF_W-1:0] off;
  logic             wr, rd, acc, csr_wr, cmd_wr, cmd_side;

  assign bank   = bank_e'(hst_addr[HA_W-1 -: 2]);
  assign off    = hst_addr[OFF_W-1:0];
  assign wr     = hst_wr;
  assign rd     = hst_rd & ~hst_wr;
  assign acc    = wr | rd;
  assign csr_wr = wr && (bank == BK_CSR);
  assign cmd_wr = csr_wr && (off == OFF_W'(OFS_CMD));
  assign cmd_side = hst_wdata[CMD_SIDE];

  logic [NCHAN-1:0]  busy, msel, arm, step, win;
  logic [MEM_AW-1:0] ch_addr [NCHAN];
  logic [CNT_W-1:0]  ch_rem  [NCHAN];

  for (genvar i = 0; i < NCHAN; i++) begin : g_chan
    assign win[i]  = acc && (bank == bank_e'(i + 1));
    assign step[i] = win[i] & busy[i];
    assign arm[i]  = cmd_wr && (cmd_side == 1'(i));
    bd_chan #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .arm      (arm[i]),
      .arm_msel (hst_wdata[CMD_MSEL]),
      .arm_base (hst_wdata[MEM_AW-1:0]),
      .arm_cnt  (hst_wdata[CMD_CNT_LSB +: CNT_W]),
      .step     (step[i]),
      .busy     (busy[i]),
      .msel     (msel[i]),
      .addr     (ch_addr[i]),
      .remain   (ch_rem[i])
    );
  end

  logic       data_miss, ovr_set;
  logic [2:0] st_set, st_clr, sticky;

  assign data_miss = |(win & ~busy);
  assign ovr_set   = cmd_wr && busy[cmd_side];
  assign st_set    = {cfg_valid, ovr_set, data_miss};
  assign st_clr    = (csr_wr && off == OFF_W'(OFS_STAT)) ? hst_wdata[ST_ERR +: 3] : 3'b0;

  bd_csr u_csr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set    (st_set),
    .clr    (st_clr),
    .sticky (sticky)
  );

  logic err, ovr;
  assign err = sticky[0];
  assign ovr = sticky[1];

  logic [DW-1:0] scr_q;
  bd_scratch #(.DW(DW), .AW(SCR_AW)) u_scr (
    .clk   (clk),
    .we    (wr && bank == BK_SCR),
    .waddr (off[SCR_AW-1:0]),
    .wdata (hst_wdata),
    .raddr (off[SCR_AW-1:0]),
    .rdata (scr_q)
  );

  assign mem_side  = (bank == BK_YDAT);
  assign mem_bsel  = msel[mem_side];
  assign mem_addr  = ch_addr[mem_side];
  assign mem_wdata = hst_wdata;
  assign mem_we    = wr & |step;
  assign mem_re    = rd & |step;
  assign cfg_valid = csr_wr && (off == OFF_W'(OFS_CFG));
  assign cfg_data  = hst_wdata;

  logic [DW-1:0] status, rd_mux;
  always_comb begin
    status = '0;
    status[ST_BUSY0 +: NCHAN] = busy;
    status[ST_ERR +: 3]       = sticky;
  end

  always_comb begin
    rd_mux = '0;
    unique case (bank)
      BK_CSR: begin
        if      (off == OFF_W'(OFS_STAT)) rd_mux = status;
        else if (off == OFF_W'(OFS_VER))  rd_mux = DW'(VERSION);
        else if (off == OFF_W'(OFS_XREM)) rd_mux = DW'(ch_rem[0]);
        else if (off == OFF_W'(OFS_YREM)) rd_mux = DW'(ch_rem[1]);
      end
      BK_XDAT: if (busy[0]) rd_mux = mem_rdata;
      BK_YDAT: if (busy[1]) rd_mux = mem_rdata;
      default: rd_mux = scr_q;
    endcase
  end

  logic [DW-1:0] rdata_q;
  logic          rvalid_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign hst_rdata  = rdata_q;
  assign hst_rvalid = rvalid_q;
endmodule

// File: rtl/bd_top_chk.sv
module bd_top_chk #(
  parameter int HA_W = 10,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hst_wr,
  input logic            hst_rd,
  input logic [HA_W-1:0] hst_addr,
  input logic [DW-1:0]   hst_wdata,
  input logic            hst_rvalid,
  input logic            mem_we,
  input logic            mem_re,
  input logic            cfg_valid,
  input logic [1:0]      busy,
  input logic            err,
  input logic            ovr
);
  logic [1:0] bk;
  logic       is_cmd;
  assign bk     = hst_addr[HA_W-1 -: 2];
  assign is_cmd = hst_wr && bk == 2'd0 && hst_addr[HA_W-3:0] == '0;

  a_r13_rvalid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && !hst_wr) |=> hst_rvalid);

  a_r13_rvalid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    hst_rvalid |-> $past(hst_rd && !hst_wr));

  a_r7_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy != 2'b00));

  a_r7_err_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && bk == 2'd1 && !busy[0]) |=> err);

  a_r9_ovr_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && busy[hst_wdata[31]]) |=> ovr);

  a_r9_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && busy[0] && !hst_wdata[31]) |=> busy[0]);

  a_r5_one_mem_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r10_cfg_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> hst_wr);
endmodule

bind bd_top bd_top_chk #(.HA_W(HA_W), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .hst_wr     (hst_wr),
  .hst_rd     (hst_rd),
  .hst_addr   (hst_addr),
  .hst_wdata  (hst_wdata),
  .hst_rvalid (hst_rvalid),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .cfg_valid  (cfg_valid),
  .busy       (busy),
  .err        (err),
  .ovr        (ovr)
);

// File: tb/bd_top_bench.sv
module bd_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hst_wr, hst_rd;
  logic [9:0]  hst_addr;
  logic [31:0] hst_wdata, hst_rdata, mem_wdata, mem_rdata, cfg_data;
  logic        hst_rvalid, mem_we, mem_re, mem_side, mem_bsel, cfg_valid;
  logic [11:0] mem_addr;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bd_top u_bd_top (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .hst_rvalid(hst_rvalid), .mem_we(mem_we), .mem_re(mem_re),
    .mem_side(mem_side), .mem_bsel(mem_bsel), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cfg_valid(cfg_valid),
    .cfg_data(cfg_data)
  );

  assign mem_rdata = 32'hD000_0000 | (32'(mem_side) << 13) | (32'(mem_bsel) << 12) | 32'(mem_addr);

  logic [31:0] log_word [32];
  int          log_n = 0;
  int          cfg_n = 0;
  logic [31:0] cfg_last;
  always @(posedge clk) begin
    if (mem_we) begin
      log_word[log_n % 32] <= {mem_side, mem_bsel, 2'b00, mem_addr, mem_wdata[15:0]};
      log_n <= log_n + 1;
    end
    if (cfg_valid) begin
      cfg_n    <= cfg_n + 1;
      cfg_last <= cfg_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] bk, input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = {bk, off}; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] bk, input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    hst_rd = 1'b1; hst_addr = {bk, off};
    @(negedge clk);
    hst_rd = 1'b0;
    chk("R13 rvalid", 32'(hst_rvalid), 32'd1);
    d = hst_rdata;
  endtask

  function automatic logic [31:0] cmd(input bit side, input bit ms, input int cnt, input int base);
    return (32'(side) << 31) | (32'(ms) << 30) | (32'(cnt) << 16) | 32'(base);
  endfunction

  function automatic logic [31:0] entry(input bit side, input bit ms, input int a, input int d);
    return {side, ms, 2'b00, 12'(a), 16'(d)};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rvalid", 32'(hst_rvalid), 0);
    chk("R1 mem_we", 32'({mem_we, mem_re, cfg_valid}), 0);
    rd(2'd0, 8'd1, d); chk("R1 status", d, 0);
  endtask

  task automatic t_version();
    logic [31:0] d;
    rd(2'd0, 8'd3, d); chk("R11 version", d, 32'h0001_0004);
  endtask

  task automatic t_scratch();
    logic [31:0] d;
    wr(2'd3, 8'd5, 32'h1111_0005);
    wr(2'd3, 8'd63, 32'h2222_003F);
    wr(2'd3, 8'd0, 32'h3333_0000);
    rd(2'd3, 8'd5, d);  chk("R3 off5", d, 32'h1111_0005);
    rd(2'd3, 8'd63, d); chk("R3 off63", d, 32'h2222_003F);
    wr(2'd3, 8'd5, 32'h4444_0055);
    rd(2'd3, 8'd5, d);  chk("R2 R3 overwrite", d, 32'h4444_0055);
  endtask

  task automatic t_unarmed();
    logic [31:0] d;
    int n0 = log_n;
    wr(2'd1, 8'd0, 32'hBAD0);
    chk("R7 dropped", 32'(log_n - n0), 0);
    rd(2'd0, 8'd1, d); chk("R7 err bit", d, 32'h4);
    wr(2'd0, 8'd1, 32'h4);
    rd(2'd0, 8'd1, d); chk("R12 clear err", d, 0);
  endtask

  task automatic t_dma_x();
    logic [31:0] d;
    int n0 = log_n;
    wr(2'd0, 8'd0, cmd(0, 1, 3, 500));
    rd(2'd0, 8'd1, d); chk("R4 busy X", d, 32'h1);
    rd(2'd0, 8'd4, d); chk("R6 remain 3", d, 3);
    for (int i = 0; i < 3; i++) wr(2'd1, 8'd0, 32'hA000 + 32'(i));
    chk("R5 count", 32'(log_n - n0), 3);
    for (int i = 0; i < 3; i++)
      chk("R5 word", log_word[(n0 + i) % 32], entry(0, 1, 500 + i, 'hA000 + i));
    rd(2'd0, 8'd1, d); chk("R6 idle", d, 0);
    rd(2'd0, 8'd4, d); chk("R6 remain 0", d, 0);
  endtask

  task automatic t_overrun_read();
    logic [31:0] d;
    wr(2'd0, 8'd0, cmd(1, 0, 2, 10));
    wr(2'd0, 8'd0, cmd(1, 1, 5, 99));
    rd(2'd0, 8'd1, d); chk("R9 ovr bit", d, 32'h0A);
    rd(2'd0, 8'd5, d); chk("R9 remain kept", d, 2);
    rd(2'd2, 8'd0, d); chk("R8 first", d, 32'hD000_2000 | 32'd10);
    rd(2'd2, 8'd0, d); chk("R8 second", d, 32'hD000_2000 | 32'd11);
    rd(2'd0, 8'd1, d); chk("R8 done", d, 32'h08);
    wr(2'd0, 8'd1, 32'h08);
    rd(2'd0, 8'd1, d); chk("R12 clear ovr", d, 0);
  endtask

  task automatic t_zero_and_wrap();
    logic [31:0] d;
    int n0;
    wr(2'd0, 8'd0, cmd(0, 0, 0, 7));
    rd(2'd0, 8'd1, d); chk("R4 zero count idle", d, 0);
    n0 = log_n;
    wr(2'd0, 8'd0, cmd(0, 0, 2, 4095));
    wr(2'd1, 8'd9, 32'hB001);
    wr(2'd1, 8'd9, 32'hB002);
    chk("R5 wrap a", log_word[n0 % 32], entry(0, 0, 4095, 'hB001));
    chk("R5 wrap b", log_word[(n0 + 1) % 32], entry(0, 0, 0, 'hB002));
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    int n0 = cfg_n;
    wr(2'd0, 8'd2, 32'hCAFE_F00D);
    chk("R10 pulses", 32'(cfg_n - n0), 1);
    chk("R10 data", cfg_last, 32'hCAFE_F00D);
    rd(2'd0, 8'd1, d); chk("R10 cfg bit", d, 32'h10);
    wr(2'd0, 8'd1, 32'h10);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    @(negedge clk);
    hst_wr = 1'b1; hst_rd = 1'b1; hst_addr = {2'd3, 8'd7}; hst_wdata = 32'h7777;
    @(negedge clk);
    hst_wr = 1'b0; hst_rd = 1'b0;
    chk("R13 no rvalid on write", 32'(hst_rvalid), 0);
    rd(2'd3, 8'd7, d); chk("R13 write done", d, 32'h7777);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hst_wr = 1'b0; hst_rd = 1'b0; hst_addr = '0; hst_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_version();
    t_scratch();
    t_unarmed();
    t_dma_x();
    t_overrun_read();
    t_zero_and_wrap();
    t_cfg();
    t_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule